// File: doc/BRIEF.md
# Parallel Memory Cycle Controller

This block sits on the host side of a 32K x 8 parallel nonvolatile memory whose cycles are started by a falling chip enable. It accepts one read or write at a time on a valid/ready request port and turns it into one complete bus cycle. The cycle has four counted phases: address setup with chip enable high, the access itself, a write commit phase, and a mandatory precharge with chip enable high. Each phase length is a separate parameter in clock cycles.

Writes come in two styles, chosen per request. In the enable-controlled style, write enable goes low before chip enable falls. In the strobe-controlled style, chip enable falls first and write enable is pulsed low near the end of the cycle. Reads drive output enable low during the access phase and sample the data bus at the last access edge. The result is returned with a one-cycle strobe. The data pins are a pad-side tri-state triple: an output value, an output enable and an input value.

Reads and writes take the same number of cycles, so the host sees a fixed service time. No status polling is needed between cycles.

Top module: `pmem_cycle_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, and mem_ce_no, mem_we_no and mem_oe_no are 1. mem_dq_oe_o, rsp_valid_o and mem_addr_o are 0.
- R2: A request is taken on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o then stays 0 for exactly SETUP_CYC+ACCESS_CYC+DSETUP_CYC+PRECH_CYC cycles. This count is the same for reads and writes.
- R3: mem_addr_o carries the request address for the SETUP_CYC cycles before mem_ce_no falls and for the first HOLD_CYC cycles with mem_ce_no low. At every other time it is 0.
- R4: mem_ce_no stays low for exactly ACCESS_CYC+DSETUP_CYC cycles per transfer.
- R5: Between one rise of mem_ce_no and the next fall, mem_ce_no stays high for at least PRECH_CYC+1+SETUP_CYC cycles. This count is one idle cycle plus setup.
- R6: A write with req_mode_i=0 is enable-controlled. mem_we_no is already low when mem_ce_no falls, and it stays low while mem_ce_no is low. mem_oe_no stays 1.
- R7: A write with req_mode_i=1 is strobe-controlled. mem_we_no is 1 when mem_ce_no falls. It is low only in the last DSETUP_CYC cycles of mem_ce_no low. mem_oe_no stays 1.
- R8: During a write, mem_dq_oe_o is 1 and mem_dq_o equals the request data while mem_ce_no is low. The data stays stable up to the rising edge that ends the write. The write then lands in the memory.
- R9: During a read, mem_dq_oe_o is 0 and mem_oe_no is low for the first ACCESS_CYC cycles of mem_ce_no low. The bus is sampled at the last of those cycles. It is returned on rsp_rdata_o with rsp_valid_o high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request may be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mode_i | input | 1 | Write style: 0 = enable-controlled, 1 = strobe-controlled |
| req_addr_i | input | 15 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | 8 | Read data |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_addr_o | output | 15 | Memory address |
| mem_dq_o | output | 8 | Data to pad |
| mem_dq_oe_o | output | 1 | Pad output enable |
| mem_dq_i | input | 8 | Data from pad |

## Verification
The embedded assertions check cycle-local properties on every edge:
- the idle pin state whenever ready is high;
- write enable and output enable never low together;
- the pad never driven while output enable is low;
- a single-cycle response strobe;
- at least one high cycle after each chip enable rise;
- an address that does not move at the chip enable fall;
- write data that does not change while it is driven with chip enable low.

Only the bench scenarios can show the exact phase lengths, the precharge gap and the hold window on the address. The same is true of the differing strobe placement in the two write styles. The bench also shows that data written in one style reads back correctly through a behavioural memory, including a read issued immediately after a write to the same address.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_COMMIT,
    ST_PRECH
  } pmem_st_e;
endpackage

// File: rtl/pmem_tick_cnt.sv
module pmem_tick_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o); // R4
endmodule

// File: rtl/pmem_seq.sv
module pmem_seq
  import pmem_pkg::*;
#(
  parameter int AW         = 15,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 2,
  parameter int ACCESS_CYC = 3,
  parameter int DSETUP_CYC = 2,
  parameter int PRECH_CYC  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_mode_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic          req_ready_o,
  output pmem_st_e      st_o,
  output logic          is_wr_o,
  output logic          wmode_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          setup_end_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  localparam int MAX_AB = (SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC;
  localparam int MAX_CD = (DSETUP_CYC > PRECH_CYC) ? DSETUP_CYC : PRECH_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_SETUP  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LD_ACCESS = CW'(ACCESS_CYC - 1);
  localparam logic [CW-1:0] LD_DSETUP = CW'(DSETUP_CYC - 1);
  localparam logic [CW-1:0] LD_PRECH  = CW'(PRECH_CYC - 1);

  pmem_st_e      st_q, st_d;
  logic          ph_ld, ph_zero;
  logic [CW-1:0] ph_val;
  logic          acc_end;

  pmem_tick_cnt #(.W(CW)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ph_ld), .load_val_i(ph_val), .zero_o(ph_zero)
  );

  always_comb begin
    st_d   = st_q;
    ph_ld  = 1'b0;
    ph_val = '0;
    unique case (st_q)
      ST_IDLE:   if (req_valid_i) begin st_d = ST_SETUP;  ph_ld = 1'b1; ph_val = LD_SETUP;  end
      ST_SETUP:  if (ph_zero)     begin st_d = ST_ACCESS; ph_ld = 1'b1; ph_val = LD_ACCESS; end
      ST_ACCESS: if (ph_zero)     begin st_d = ST_COMMIT; ph_ld = 1'b1; ph_val = LD_DSETUP; end
      ST_COMMIT: if (ph_zero)     begin st_d = ST_PRECH;  ph_ld = 1'b1; ph_val = LD_PRECH;  end
      ST_PRECH:  if (ph_zero)           st_d = ST_IDLE;
      default:                          st_d = ST_IDLE;
    endcase
  end

  assign acc_end = (st_q == ST_ACCESS) && ph_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      is_wr_o     <= 1'b0;
      wmode_o     <= 1'b0;
      addr_o      <= '0;
      wdata_o     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_o <= acc_end && !is_wr_o;
      if (acc_end && !is_wr_o) rsp_rdata_o <= dq_i;
      if (st_q == ST_IDLE && req_valid_i) begin
        is_wr_o <= req_write_i;
        wmode_o <= req_mode_i;
        addr_o  <= req_addr_i;
        wdata_o <= req_wdata_i;
      end
    end
  end

  assign st_o        = st_q;
  assign req_ready_o = (st_q == ST_IDLE);
  assign setup_end_o = (st_q == ST_SETUP) && ph_zero;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R9
  AST_NO_REACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i) |=> !req_ready_o); // R2
endmodule

// File: rtl/pmem_pin_drv.sv
module pmem_pin_drv
  import pmem_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  pmem_st_e      st_i,
  input  logic          is_wr_i,
  input  logic          wmode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          hold_act_i,
  output logic          ce_no,
  output logic          we_no,
  output logic          oe_no,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic ce_act, busy;

  assign ce_act = (st_i == ST_ACCESS) || (st_i == ST_COMMIT);
  assign busy   = (st_i == ST_SETUP) || ce_act;

  assign ce_no   = !ce_act;
  // mode 0: strobe spans setup..commit; mode 1: strobe only in commit
  assign we_no   = !(is_wr_i && (wmode_i ? (st_i == ST_COMMIT) : busy));
  assign oe_no   = !(!is_wr_i && (st_i == ST_ACCESS));
  assign dq_oe_o = is_wr_i && busy;
  assign dq_o    = dq_oe_o ? wdata_i : '0;
  assign addr_o  = ((st_i == ST_SETUP) || (ce_act && hold_act_i)) ? addr_i : '0;
endmodule

// File: rtl/pmem_cycle_ctrl.sv
module pmem_cycle_ctrl
  import pmem_pkg::*;
#(
  parameter int AW         = 15,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 2,
  parameter int ACCESS_CYC = 3,
  parameter int DSETUP_CYC = 2,
  parameter int HOLD_CYC   = 2,
  parameter int PRECH_CYC  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_mode_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  pmem_st_e      st;
  logic          is_wr, wmode, setup_end, hold_zero;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  pmem_seq #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .ACCESS_CYC(ACCESS_CYC),
    .DSETUP_CYC(DSETUP_CYC), .PRECH_CYC(PRECH_CYC)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_mode_i(req_mode_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .dq_i(mem_dq_i),
    .req_ready_o(req_ready_o), .st_o(st), .is_wr_o(is_wr), .wmode_o(wmode),
    .addr_o(addr_q), .wdata_o(wdata_q), .setup_end_o(setup_end),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o)
  );

  // address hold window, counted from the chip enable fall
  pmem_tick_cnt #(.W(HW)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(setup_end),
    .load_val_i(HW'(HOLD_CYC)), .zero_o(hold_zero)
  );

  pmem_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .st_i(st), .is_wr_i(is_wr), .wmode_i(wmode), .addr_i(addr_q), .wdata_i(wdata_q),
    .hold_act_i(!hold_zero),
    .ce_no(mem_ce_no), .we_no(mem_we_no), .oe_no(mem_oe_no), .addr_o(mem_addr_o),
    .dq_o(mem_dq_o), .dq_oe_o(mem_dq_oe_o)
  );

  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && mem_oe_no && !mem_dq_oe_o)); // R1
  AST_BUSY_WHILE_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !req_ready_o); // R2
  AST_ADDR_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> $stable(mem_addr_o)); // R3
  AST_PRECH_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |=> mem_ce_no); // R5
  AST_OE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no); // R6
  AST_WDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && mem_dq_oe_o) |-> $stable(mem_dq_o)); // R8
  AST_NO_BUS_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o); // R9
endmodule

// File: tb/pmem_cycle_ctrl_tb.sv
module pmem_cycle_ctrl_tb;
  localparam int S = 2, A = 3, D = 2, H = 2, P = 3;
  localparam int BUSY = S + A + D + P;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_mode = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  rsp_rdata, dq_o, mdl_rd;
  logic [14:0] mem_addr;

  always #10 clk = ~clk;

  pmem_cycle_ctrl #(.SETUP_CYC(S), .ACCESS_CYC(A), .DSETUP_CYC(D), .HOLD_CYC(H), .PRECH_CYC(P)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_mode_i(req_mode), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .mem_ce_no(ce_n), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_addr_o(mem_addr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(mdl_rd)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [int];
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];
  logic [14:0] la = '0;

  always @(*) begin
    mdl_rd = 8'h5A;
    if (!ce_n && !oe_n && mdl.exists(int'(la))) mdl_rd = mdl[int'(la)];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit cur_wr = 0, cur_mode = 0;
  logic [14:0] cur_addr = '0;
  logic [7:0]  cur_data = '0;

  task automatic issue(input bit wr, input bit mode, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_wr = wr; cur_mode = mode; cur_addr = a; cur_data = d;
    req_valid = 1'b1; req_write = wr; req_mode = mode; req_addr = a; req_wdata = d;
    if (wr) shadow[int'(a)] = d;
    else    exp_q.push_back(shadow[int'(a)]);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory model and monitor, all at the falling edge
  logic prev_ce = 1'b1, prev_ready = 1'b1, wpend = 1'b0, seen_rise = 1'b0;
  int ce_lo = 0, ce_hi = 0, busy = 0;
  logic [14:0] wa;
  logic [7:0]  wd, e;

  always @(negedge clk) if (rst_ni) begin
    if (prev_ce && !ce_n) begin
      la = mem_addr;
      chk(mem_addr == cur_addr, "R3 addr at ce fall", mem_addr, cur_addr);
      if (cur_wr) chk(we_n == cur_mode, cur_mode ? "R7 we high at ce fall" : "R6 we low at ce fall", we_n, cur_mode);
      if (seen_rise) chk(ce_hi >= P + 1 + S, "R5 precharge gap", ce_hi, P + 1 + S);
      ce_lo = 0;
    end
    if (!ce_n) begin
      ce_lo++;
      chk(mem_addr == ((ce_lo <= H) ? cur_addr : 15'd0), "R3 addr hold window", mem_addr, (ce_lo <= H) ? cur_addr : 0);
      if (cur_wr) begin
        chk(dq_oe && dq_o == cur_data, "R8 write data driven", dq_o, cur_data);
        chk(oe_n, cur_mode ? "R7 oe high" : "R6 oe high", oe_n, 1);
        if (cur_mode) chk(we_n == (ce_lo <= A), "R7 we strobe placement", we_n, ce_lo <= A);
        else          chk(!we_n, "R6 we low through cycle", we_n, 0);
      end else begin
        chk(!dq_oe, "R9 pad released on read", dq_oe, 0);
        chk(oe_n == (ce_lo > A), "R9 oe window", oe_n, ce_lo > A);
      end
    end
    if (!prev_ce && ce_n) begin
      chk(ce_lo == A + D, "R4 ce low length", ce_lo, A + D);
      seen_rise = 1'b1;
      ce_hi = 0;
    end
    if (ce_n) ce_hi++;
    // write lands at the first strobe rise
    if (!ce_n && !we_n) begin wpend = 1'b1; wd = dq_o; wa = la; end
    else if (wpend) begin mdl[int'(wa)] = wd; wpend = 1'b0; end
    if (!req_ready) busy++;
    if (!prev_ready && req_ready) begin
      chk(busy == BUSY, "R2 busy length", busy, BUSY);
      busy = 0;
    end
    if (rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected response", rsp_rdata, 0);
      else begin
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R9 read data", rsp_rdata, e);
      end
    end
    prev_ce = ce_n;
    prev_ready = req_ready;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && ce_n && we_n && oe_n && !dq_oe && !rsp_valid && mem_addr == 0,
        "R1 reset pins", {req_ready, ce_n, we_n, oe_n, dq_oe, rsp_valid}, 6'b111100);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready && ce_n && mem_addr == 0, "R1 idle after reset", {req_ready, ce_n}, 2'b11);

    issue(1, 0, 15'h0000, 8'h11);
    issue(1, 0, 15'h7FFF, 8'hEE);
    issue(1, 1, 15'h1234, 8'hA5);
    issue(1, 1, 15'h0ABC, 8'h3C);
    issue(0, 0, 15'h0000, 8'h00);
    issue(0, 1, 15'h7FFF, 8'h00);
    issue(0, 0, 15'h1234, 8'h00);
    issue(0, 0, 15'h0ABC, 8'h00);
    issue(1, 0, 15'h1234, 8'h5C);   // overwrite, then read at once
    issue(0, 0, 15'h1234, 8'h00);
    issue(1, 1, 15'h4321, 8'hFF);
    issue(0, 1, 15'h4321, 8'h00);
    issue(1, 1, 15'h7FFF, 8'h00);
    issue(0, 0, 15'h7FFF, 8'h00);

    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    foreach (shadow[k]) begin
      chk(mdl.exists(k) && mdl[k] == shadow[k], "R8 stored byte", mdl.exists(k) ? mdl[k] : 8'hxx, shadow[k]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule